// File: doc/BRIEF.md
# Occupancy-Matched Data Queue

This block is a sixteen-word, byte-wide first-in first-out queue for the path between a register interface and a serial shifter. It serves either direction: on the transmit side the register interface pushes and the shifter pops, and on the receive side the roles swap. The queue reports how many words it holds as a 5-bit count from 0 to 16.

An interrupt flag is set whenever the count equals a programmable 5-bit level. This lets software wake up at any chosen fill point, not just at full or empty. The flag and a sticky overflow flag are both cleared by one-cycle clear pulses, which model write-one-to-clear register bits. The interrupt output is the flag gated by an enable. While the run input is held low, both pointers and the count are forced to zero and all traffic is ignored.

Top module: `match_fifo`

## Requirements
- R1: After rst_ni is asserted low, count_o is 0, pop_data_o is 0, and irq_flag_o, irq_o and ovf_flag_o are 0.
- R2: With fifo_run_i high, an accepted push adds one to count_o and an accepted pop subtracts one. Words leave in the order they entered. A popped word appears on pop_data_o one clock edge after the pop and is held there until the next accepted pop.
- R3: A push and a pop in the same cycle while count_o is nonzero leave count_o unchanged and keep the word order. When count_o is 0, the same pair stores the word, ignores the pop and takes count_o to 1.
- R4: A push without a pop while count_o is 16 discards the word and leaves the queue contents and count_o unchanged. It also sets ovf_flag_o on the next edge.
- R5: A pop while count_o is 0 leaves count_o at 0 and leaves pop_data_o at its last value.
- R6: At each clock edge where count_o equals level_i and irq_clr_i is low, irq_flag_o becomes 1. This holds for every level from 0 to 16, including 16.
- R7: irq_flag_o stays set after count_o moves away from level_i and falls only on an edge where irq_clr_i is 1. Clear wins over a match in the same cycle, so if the match persists the flag is set again one edge later.
- R8: irq_o is 1 exactly when irq_flag_o is 1 and irq_en_i is 1. irq_en_i does not change irq_flag_o.
- R9: ovf_flag_o falls on an edge where ovf_clr_i is 1. If an overflowing push occurs in the same cycle as the clear, the flag stays 1.
- R10: While fifo_run_i is 0, count_o is forced to 0 on each edge and pushes are ignored. After fifo_run_i returns to 1, the first word pushed is the first word popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_run_i | input | 1 | 0 holds the pointers and count at zero; 1 allows operation |
| push_i | input | 1 | Write request |
| push_data_i | input | 8 | Word to write |
| pop_i | input | 1 | Read request |
| pop_data_o | output | 8 | Last word read |
| count_o | output | 5 | Number of stored words, 0 to 16 |
| level_i | input | 5 | Count that sets the interrupt flag |
| irq_en_i | input | 1 | Interrupt output enable |
| irq_clr_i | input | 1 | Clear pulse for the interrupt flag |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |
| irq_flag_o | output | 1 | Level-match flag |
| irq_o | output | 1 | Gated interrupt |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
A vector table drives push only, pop only, paired push and pop with a nonempty queue, paired push and pop with an empty queue, and a pop from an empty queue. Checking count and output word after each step separates a correct pointer update from a count that moves on a discarded request.

Directed runs fill the queue to sixteen and then push once more. Draining the queue afterwards shows whether the extra word overwrote a stored entry or was dropped as required. Separate runs place the level at 16, clear the flag while the match still holds, and collide a clear pulse with an overflow event; together these show the priority between set and clear on each flag.

// File: rtl/match_fifo_pkg.sv
package match_fifo_pkg;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_WIDTH = 8;

  typedef struct packed {
    logic wr;   // word accepted into storage
    logic rd;   // word taken from storage
    logic ovf;  // push dropped because full
  } mf_op_t;
endpackage

// File: rtl/mf_ctrl.sv
module mf_ctrl
  import match_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             run_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] cnt_i,
  output mf_op_t           op_o
);
  logic full, empty;

  assign full  = (cnt_i == CNT_W'(DEPTH));
  assign empty = (cnt_i == '0);

  always_comb begin
    op_o.rd  = run_i & pop_i & ~empty;
    // a simultaneous pop frees a slot for the push
    op_o.wr  = run_i & push_i & (~full | op_o.rd);
    op_o.ovf = run_i & push_i & full & ~op_o.rd;
  end
endmodule

// File: rtl/mf_ptrs.sv
module mf_ptrs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (!run_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (rd_i) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/mf_store.sv
module mf_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             rd_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [WIDTH-1:0] ent_rd [DEPTH];
  logic [WIDTH-1:0] dout_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [WIDTH-1:0] ent_q;
    always_ff @(posedge clk_i) begin
      if (wr_i && wr_ptr_i == PTR_W'(g)) ent_q <= din_i;
    end
    assign ent_rd[g] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= '0;
    else if (rd_i) dout_q <= ent_rd[rd_ptr_i];
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/mf_flags.sv
module mf_flags #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic             irq_clr_i,
  input  logic             ovf_set_i,
  input  logic             ovf_clr_i,
  output logic             irq_flag_o,
  output logic             ovf_flag_o
);
  logic irq_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      // clear beats a match; a lasting match re-sets next edge
      if (irq_clr_i)            irq_q <= 1'b0;
      else if (cnt_i == level_i) irq_q <= 1'b1;
      // a new overflow beats its clear so no event is lost
      if (ovf_set_i)            ovf_q <= 1'b1;
      else if (ovf_clr_i)       ovf_q <= 1'b0;
    end
  end

  assign irq_flag_o = irq_q;
  assign ovf_flag_o = ovf_q;
endmodule

// File: rtl/match_fifo.sv
module match_fifo
  import match_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned DEPTH = DEF_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_run_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [CNT_W-1:0] count_o,
  input  logic [CNT_W-1:0] level_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  input  logic             ovf_clr_i,
  output logic             irq_flag_o,
  output logic             irq_o,
  output logic             ovf_flag_o
);
  mf_op_t           op;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  mf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .run_i (fifo_run_i),
    .push_i(push_i),
    .pop_i (pop_i),
    .cnt_i (cnt),
    .op_o  (op)
  );

  mf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (fifo_run_i),
    .wr_i    (op.wr),
    .rd_i    (op.rd),
    .wr_ptr_o(wr_ptr),
    .rd_ptr_o(rd_ptr),
    .cnt_o   (cnt)
  );

  mf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (op.wr),
    .wr_ptr_i(wr_ptr),
    .din_i   (push_data_i),
    .rd_i    (op.rd),
    .rd_ptr_i(rd_ptr),
    .dout_o  (pop_data_o)
  );

  mf_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .level_i   (level_i),
    .irq_clr_i (irq_clr_i),
    .ovf_set_i (op.ovf),
    .ovf_clr_i (ovf_clr_i),
    .irq_flag_o(irq_flag_o),
    .ovf_flag_o(ovf_flag_o)
  );

  assign count_o = cnt;
  assign irq_o   = irq_flag_o & irq_en_i;
endmodule

// File: rtl/mf_chk.sv
module mf_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_run_i,
  input logic             push_i,
  input logic             pop_i,
  input logic [WIDTH-1:0] pop_data_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] level_i,
  input logic             irq_en_i,
  input logic             irq_clr_i,
  input logic             irq_flag_o,
  input logic             irq_o,
  input logic             ovf_flag_o
);
  // R2
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  // R3
  pair_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_run_i && push_i && pop_i && count_o != '0) |=> $stable(count_o));

  // R4
  full_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_run_i && push_i && !pop_i && count_o == CNT_W'(DEPTH))
      |=> (ovf_flag_o && count_o == CNT_W'(DEPTH)));

  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && count_o == '0) |=> ($stable(pop_data_o) && count_o == '0));

  // R6
  match_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == level_i && !irq_clr_i) |=> irq_flag_o);

  // R7
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i |=> !irq_flag_o);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  // R10
  run_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_run_i |=> count_o == '0);
endmodule

bind match_fifo mf_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mf_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fifo_run_i(fifo_run_i),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .pop_data_o(pop_data_o),
  .count_o   (count_o),
  .level_i   (level_i),
  .irq_en_i  (irq_en_i),
  .irq_clr_i (irq_clr_i),
  .irq_flag_o(irq_flag_o),
  .irq_o     (irq_o),
  .ovf_flag_o(ovf_flag_o)
);

// File: tb/match_fifo_bench.sv
`timescale 1ns/1ps
module match_fifo_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_run_i = 1'b1;
  logic       push_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic       pop_i = 1'b0;
  logic [7:0] pop_data_o;
  logic [4:0] count_o;
  logic [4:0] level_i = 5'd5;
  logic       irq_en_i = 1'b1;
  logic       irq_clr_i = 1'b0;
  logic       ovf_clr_i = 1'b0;
  logic       irq_flag_o, irq_o, ovf_flag_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  match_fifo u_match_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_run_i(fifo_run_i),
    .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
    .pop_data_o(pop_data_o), .count_o(count_o), .level_i(level_i),
    .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i), .ovf_clr_i(ovf_clr_i),
    .irq_flag_o(irq_flag_o), .irq_o(irq_o), .ovf_flag_o(ovf_flag_o)
  );

  // {push, pop, data[7:0], exp_count[4:0], exp_pop_data[7:0]}
  localparam int NVEC = 10;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h11, 5'd1, 8'h00},
    {1'b1, 1'b0, 8'h22, 5'd2, 8'h00},
    {1'b1, 1'b0, 8'h33, 5'd3, 8'h00},
    {1'b1, 1'b1, 8'h44, 5'd3, 8'h11},
    {1'b0, 1'b1, 8'h00, 5'd2, 8'h22},
    {1'b0, 1'b1, 8'h00, 5'd1, 8'h33},
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h44},
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h44},
    {1'b1, 1'b1, 8'h55, 5'd1, 8'h44},
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h55}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic push_one(input logic [7:0] d);
    push_i = 1'b1; push_data_i = d; tick(); push_i = 1'b0;
  endtask

  task automatic pop_one();
    pop_i = 1'b1; tick(); pop_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk("R1 count", count_o, 0);
    chk("R1 pop_data", pop_data_o, 0);
    chk("R1 irq_flag", irq_flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 ovf", ovf_flag_o, 0);
    rst_ni = 1'b1;
    level_i = 5'd3;
    tick();

    // R2 R3 R5 table
    for (int i = 0; i < NVEC; i++) begin
      push_i = VEC[i][22]; pop_i = VEC[i][21]; push_data_i = VEC[i][20:13];
      tick();
      chk($sformatf("R2/R3/R5 vec%0d count", i), count_o, int'(VEC[i][12:8]));
      chk($sformatf("R2/R3/R5 vec%0d data", i), pop_data_o, int'(VEC[i][7:0]));
    end
    push_i = 1'b0; pop_i = 1'b0;

    // R7 sticky after count left level 3; R8 gating
    chk("R7 sticky flag", irq_flag_o, 1);
    chk("R8 irq enabled", irq_o, 1);
    irq_en_i = 1'b0; #1;
    chk("R8 irq masked", irq_o, 0);
    chk("R8 flag kept", irq_flag_o, 1);
    irq_en_i = 1'b1;
    irq_clr_i = 1'b1; tick(); irq_clr_i = 1'b0;
    chk("R7 cleared", irq_flag_o, 0);

    // R6 level 16
    level_i = 5'd16;
    for (int i = 0; i < 15; i++) push_one(8'h80 + 8'(i));
    tick();
    chk("R2 count 15", count_o, 15);
    chk("R6 no match at 15", irq_flag_o, 0);
    push_one(8'h8F);
    chk("R2 count 16", count_o, 16);
    tick();
    chk("R6 match at 16", irq_flag_o, 1);

    // R4 overflow discard
    push_one(8'hEE);
    chk("R4 count stays", count_o, 16);
    chk("R4 ovf set", ovf_flag_o, 1);

    // R7 clear while match persists
    irq_clr_i = 1'b1; tick(); irq_clr_i = 1'b0;
    chk("R7 clear wins", irq_flag_o, 0);
    tick();
    chk("R7 re-set", irq_flag_o, 1);

    for (int i = 0; i < 16; i++) begin
      pop_one();
      chk($sformatf("R4 order word%0d", i), pop_data_o, 'h80 + i);
    end
    chk("R4 drained", count_o, 0);

    // R9 clear and collision
    ovf_clr_i = 1'b1; tick(); ovf_clr_i = 1'b0;
    chk("R9 ovf cleared", ovf_flag_o, 0);
    for (int i = 0; i < 16; i++) push_one(8'(i));
    push_i = 1'b1; push_data_i = 8'hEE; ovf_clr_i = 1'b1;
    tick();
    push_i = 1'b0; ovf_clr_i = 1'b0;
    chk("R9 set beats clear", ovf_flag_o, 1);

    // R10 run low
    fifo_run_i = 1'b0; tick();
    chk("R10 count forced", count_o, 0);
    push_one(8'h33);
    chk("R10 push ignored", count_o, 0);
    fifo_run_i = 1'b1;
    push_one(8'h5A);
    push_one(8'h6B);
    pop_one();
    chk("R10 first word", pop_data_o, 'h5A);
    chk("R10 count", count_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule